// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Refresh

This block is a supervision timer. It counts bus clocks toward a programmable time-out and requests a system reset when software stops servicing it. Software services it only by writing a fixed pair of 16-bit key words, in order, to the refresh register. The second word must follow the first within a bounded number of bus cycles. Any other word written to that register is treated as a fault. A late second word is also a fault.

An optional window mode makes early service a fault as well. The timer count is compared with the window value at the moment the second key word lands. When the interrupt-first option is set, a fault raises an interrupt. The reset request then follows after a fixed number of bus clocks. After the single-cycle reset request the block returns to its post-reset state by itself. The enable, window, time-out and interrupt-first settings are plain input pins driven by the surrounding register logic.

Top module: `wdt_keyed`

## Requirements
- R1: A service operation is a write of 0xA602 to register address 0 followed by a write of 0xB480 to address 0. When accepted, it prevents the pending time-out.
- R2: The second key word is accepted when it arrives at most 20 cycles after the first. If the 20th cycle after the first word passes with no write to address 0, a fault is raised in that cycle.
- R3: A write to address 0 with the wrong word for the current step is a fault. This covers a first word other than 0xA602 and a second word other than 0xB480.
- R4: With `irq_first` low, a fault raised in cycle c gives `rst_req` in cycle c+1. With `irq_first` high, `irq` is high from cycle c+1 for IRQ_DLY cycles, and `rst_req` follows in cycle c+1+IRQ_DLY.
- R5: After an accepted service, the count is zero in the next cycle and counts up from there.
- R6: With `win_en` high, the second key word is accepted only if the count in that cycle is greater than `window_val`. Otherwise it is a fault.
- R7: When the count reaches `timeout_val` with no service, a fault is raised in that cycle.
- R8: While `enable` is low, the count is held at zero, and writes to address 0 have no effect. After `enable` rises, the count starts again from zero.
- R9: Writes to any address other than 0 are ignored. This includes a write to address 1 (unlock) placed between the two key words, which does not break the service sequence.
- R10: `rst_req` lasts exactly one cycle and `irq` is low while it is high. Afterwards the count is zero and the key sequence is idle, so the next time-out comes `timeout_val`+2 cycles after the reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| enable | input | 1 | Watchdog enable |
| win_en | input | 1 | Window mode enable |
| timeout_val | input | CNT_W | Time-out count |
| window_val | input | CNT_W | Window count |
| irq_first | input | 1 | Interrupt before reset on a fault |
| irq | output | 1 | Fault interrupt |
| rst_req | output | 1 | Single-cycle reset request |

## Verification
The bench builds the block with CNT_W = 12 and IRQ_DLY = 16. The key words and the 20-cycle gap limit keep their default values. It drives a time-out of 40 and a window of 20. With these values every boundary falls within about a hundred cycles of the enable edge. These boundaries are a gap of exactly 20 against 21, a second word at count 20 against 21, a time-out against a service, and the full interrupt interval before the reset. Each event is then checked for its exact cycle and not only for whether it happened.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [0:0] {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_t;

  typedef enum logic [1:0] {
    FLT_RUN = 2'd0,
    FLT_IRQ = 2'd1,
    FLT_RST = 2'd2
  } flt_st_t;

  typedef struct packed {
    logic bad_word;
    logic late;
    logic early;
    logic expired;
  } fault_vec_t;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int CNT_W = 16,
  parameter int ADDR_REFRESH = 0,
  parameter logic [DATA_W-1:0] KEY_LO = 16'hA602,
  parameter logic [DATA_W-1:0] KEY_HI = 16'hB480,
  parameter int GAP_MAX = 20,
  localparam int GAP_W = $clog2(GAP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_en,
  input  logic [CNT_W-1:0]  window_val,
  input  logic [CNT_W-1:0]  count,
  output logic              refresh_ok,
  output logic              bad_word,
  output logic              late,
  output logic              early,
  output logic              armed,
  output logic [GAP_W-1:0]  gap
);

  key_st_t          st_q, st_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic             rf_wr;

  assign rf_wr = wr_en && (wr_addr == ADDR_W'(ADDR_REFRESH));

  always_comb begin
    st_n       = st_q;
    gap_n      = gap_q;
    refresh_ok = 1'b0;
    bad_word   = 1'b0;
    late       = 1'b0;
    early      = 1'b0;
    if (!active) begin
      st_n  = KEY_IDLE;
      gap_n = '0;
    end else if (st_q == KEY_ARMED) begin
      if (rf_wr) begin
        st_n  = KEY_IDLE;
        gap_n = '0;
        if (wr_data != KEY_HI) begin
          bad_word = 1'b1;
        end else if (win_en && (count <= window_val)) begin
          early = 1'b1;
        end else begin
          refresh_ok = 1'b1;
        end
      end else if (gap_q == GAP_W'(GAP_MAX)) begin
        late  = 1'b1;
        st_n  = KEY_IDLE;
        gap_n = '0;
      end else begin
        gap_n = gap_q + 1'b1;
      end
    end else if (rf_wr) begin
      if (wr_data == KEY_LO) begin
        st_n  = KEY_ARMED;
        gap_n = GAP_W'(1);
      end else begin
        bad_word = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KEY_IDLE;
      gap_q <= '0;
    end else begin
      st_q  <= st_n;
      gap_q <= gap_n;
    end
  end

  assign armed = (st_q == KEY_ARMED);
  assign gap   = gap_q;

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             clr,
  input  logic             restart,
  input  logic [CNT_W-1:0] timeout_val,
  output logic [CNT_W-1:0] count,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_ce;

  always_comb begin
    expired = run && enable && (cnt_q >= timeout_val);
    cnt_n   = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (run) begin
      if (!enable || restart) begin
        cnt_n = '0;
      end else if (!expired) begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    cnt_ce = (cnt_n != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_n;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/wdt_fault_ctl.sv
module wdt_fault_ctl
  import wdt_pkg::*;
#(
  parameter int IRQ_DLY = 128,
  localparam int DLY_W = $clog2(IRQ_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic irq_first,
  output logic irq,
  output logic rst_req,
  output logic run,
  output logic clr
);

  flt_st_t          st_q, st_n;
  logic [DLY_W-1:0] dly_q, dly_n;

  always_comb begin
    st_n  = st_q;
    dly_n = dly_q;
    unique case (st_q)
      FLT_RUN: begin
        dly_n = '0;
        if (fault) begin
          st_n = irq_first ? FLT_IRQ : FLT_RST;
        end
      end
      FLT_IRQ: begin
        if (dly_q == DLY_W'(IRQ_DLY - 1)) begin
          st_n  = FLT_RST;
          dly_n = '0;
        end else begin
          dly_n = dly_q + 1'b1;
        end
      end
      FLT_RST: begin
        st_n  = FLT_RUN;
        dly_n = '0;
      end
      default: begin
        st_n  = FLT_RUN;
        dly_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FLT_RUN;
      dly_q <= '0;
    end else begin
      st_q  <= st_n;
      dly_q <= dly_n;
    end
  end

  assign irq     = (st_q == FLT_IRQ);
  assign rst_req = (st_q == FLT_RST);
  assign run     = (st_q == FLT_RUN);
  assign clr     = (st_q == FLT_RST);

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int CNT_W = 16,
  parameter int ADDR_REFRESH = 0,
  parameter logic [DATA_W-1:0] KEY_LO = 16'hA602,
  parameter logic [DATA_W-1:0] KEY_HI = 16'hB480,
  parameter int GAP_MAX = 20,
  parameter int IRQ_DLY = 128,
  localparam int GAP_W = $clog2(GAP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              enable,
  input  logic              win_en,
  input  logic [CNT_W-1:0]  timeout_val,
  input  logic [CNT_W-1:0]  window_val,
  input  logic              irq_first,
  output logic              irq,
  output logic              rst_req
);

  logic             run;
  logic             clr;
  logic             active;
  logic             refresh_ok;
  logic             armed;
  logic [GAP_W-1:0] gap;
  logic [CNT_W-1:0] count;
  fault_vec_t       fv;
  logic             fault;

  assign active = enable && run;
  assign fault  = |fv;

  wdt_key_seq #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .ADDR_REFRESH(ADDR_REFRESH),
    .KEY_LO      (KEY_LO),
    .KEY_HI      (KEY_HI),
    .GAP_MAX     (GAP_MAX)
  ) u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .win_en    (win_en),
    .window_val(window_val),
    .count     (count),
    .refresh_ok(refresh_ok),
    .bad_word  (fv.bad_word),
    .late      (fv.late),
    .early     (fv.early),
    .armed     (armed),
    .gap       (gap)
  );

  wdt_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .run        (run),
    .clr        (clr),
    .restart    (refresh_ok),
    .timeout_val(timeout_val),
    .count      (count),
    .expired    (fv.expired)
  );

  wdt_fault_ctl #(
    .IRQ_DLY(IRQ_DLY)
  ) u_flt (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault    (fault),
    .irq_first(irq_first),
    .irq      (irq),
    .rst_req  (rst_req),
    .run      (run),
    .clr      (clr)
  );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 16,
  parameter int GAP_MAX = 20,
  localparam int GAP_W = $clog2(GAP_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             run,
  input logic             irq,
  input logic             rst_req,
  input logic             refresh_ok,
  input logic             armed,
  input logic [GAP_W-1:0] gap,
  input logic [CNT_W-1:0] count
);

  // R5: accepted service zeroes the count on the next clock
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |=> (count == '0));

  // R8: disabled while running keeps the count at zero
  a_r8_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && run) |=> (count == '0));

  // R10: reset request lasts one cycle
  a_r10_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10: after the request the block is back to its post-reset state
  a_r10_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> ((count == '0) && !armed));

  // R10: interrupt and reset request never overlap
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !irq);

  // R4: the interrupt only ends into a reset request
  a_r4_irq_then_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> rst_req);

  // R2: the key gap never passes its limit
  a_r2_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (gap <= GAP_W'(GAP_MAX)));

endmodule

bind wdt_keyed wdt_keyed_chk #(
  .CNT_W  (CNT_W),
  .GAP_MAX(GAP_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .run       (run),
  .irq       (irq),
  .rst_req   (rst_req),
  .refresh_ok(refresh_ok),
  .armed     (armed),
  .gap       (gap),
  .count     (count)
);

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;

  localparam int CW = 12;
  localparam int D  = 16;
  localparam int T  = 40;
  localparam int W  = 20;
  localparam logic [15:0] K1 = 16'hA602;
  localparam logic [15:0] K2 = 16'hB480;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          enable = 1'b0;
  logic          win_en = 1'b0;
  logic [CW-1:0] timeout_val = CW'(T);
  logic [CW-1:0] window_val = CW'(W);
  logic          irq_first = 1'b0;
  logic          irq;
  logic          rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rst_pulses = 0, rst_hi = 0, rst_first = -1, rst_last = -1;
  int irq_hi = 0, irq_first_cyc = -1;
  logic rst_prev = 1'b0, irq_prev = 1'b0;

  wdt_keyed #(.CNT_W(CW), .IRQ_DLY(D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .enable(enable), .win_en(win_en),
    .timeout_val(timeout_val), .window_val(window_val),
    .irq_first(irq_first), .irq(irq), .rst_req(rst_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_req) begin
      rst_hi++;
      if (!rst_prev) begin
        rst_pulses++;
        if (rst_first < 0) rst_first = cyc;
        rst_last = cyc;
      end
    end
    if (irq) begin
      irq_hi++;
      if (!irq_prev && irq_first_cyc < 0) irq_first_cyc = cyc;
    end
    rst_prev = rst_req;
    irq_prev = irq;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_cycle(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr_at(int n, logic [3:0] a, logic [15:0] d);
    go_cycle(n);
    wr_addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_mon();
    rst_pulses = 0; rst_hi = 0; rst_first = -1; rst_last = -1;
    irq_hi = 0; irq_first_cyc = -1;
  endtask

  task automatic start_run(output int c0);
    clear_mon();
    enable = 1'b1;
    c0 = cyc;
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    clear_mon();
  endtask

  task automatic t_reset_state();
    check("R10 rst_req in reset", int'(rst_req), 0);
    check("R10 irq in reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_mon();
    wr_at(cyc + 2, 4'd0, 16'h1234);
    repeat (60) @(negedge clk);
    check("R8 disabled no reset", rst_pulses, 0);
  endtask

  task automatic t_timeout();
    int c0;
    start_run(c0);
    go_cycle(c0 + 2 * T + 10);
    check("R7 first time-out cycle", rst_first, c0 + T + 1);
    check("R10 second time-out cycle", rst_last, c0 + 2 * T + 3);
    check("R10 pulse count", rst_pulses, 2);
    check("R10 single-cycle pulses", rst_hi, 2);
    stop_run();
  endtask

  task automatic t_refresh();
    int c0;
    start_run(c0);
    wr_at(c0 + 10, 4'd0, K1);
    wr_at(c0 + 15, 4'd0, K2);
    go_cycle(c0 + 50);
    check("R1 no reset after service", rst_pulses, 0);
    go_cycle(c0 + 60);
    check("R5 restart timing", rst_first, c0 + 15 + 2 + T);
    stop_run();
  endtask

  task automatic t_gap();
    int c0;
    start_run(c0);
    wr_at(c0 + 5, 4'd0, K1);
    wr_at(c0 + 25, 4'd0, K2);
    go_cycle(c0 + 70);
    check("R2 gap 20 accepted", rst_first, c0 + 25 + 2 + T);
    stop_run();
    start_run(c0);
    wr_at(c0 + 5, 4'd0, K1);
    wr_at(c0 + 26, 4'd0, K2);
    go_cycle(c0 + 30);
    check("R2 gap 21 late fault", rst_first, c0 + 26);
    check("R2 one pulse", rst_pulses, 1);
    stop_run();
  endtask

  task automatic t_bad_word();
    int c0;
    start_run(c0);
    wr_at(c0 + 5, 4'd0, 16'h1234);
    go_cycle(c0 + 10);
    check("R3 wrong first word", rst_first, c0 + 6);
    stop_run();
    start_run(c0);
    wr_at(c0 + 5, 4'd0, K1);
    wr_at(c0 + 8, 4'd0, 16'hB481);
    go_cycle(c0 + 12);
    check("R3 wrong second word", rst_first, c0 + 9);
    stop_run();
  endtask

  task automatic t_unlock();
    int c0;
    start_run(c0);
    wr_at(c0 + 3, 4'd2, 16'h0BAD);
    wr_at(c0 + 5, 4'd0, K1);
    wr_at(c0 + 7, 4'd1, 16'h5555);
    wr_at(c0 + 9, 4'd0, K2);
    go_cycle(c0 + 45);
    check("R9 unlock write ignored", rst_pulses, 0);
    go_cycle(c0 + 55);
    check("R9 service still accepted", rst_first, c0 + 9 + 2 + T);
    stop_run();
  endtask

  task automatic t_window();
    int c0;
    win_en = 1'b1;
    start_run(c0);
    wr_at(c0 + 17, 4'd0, K1);
    wr_at(c0 + W, 4'd0, K2);
    go_cycle(c0 + W + 4);
    check("R6 second word at window value", rst_first, c0 + W + 1);
    stop_run();
    start_run(c0);
    wr_at(c0 + 18, 4'd0, K1);
    wr_at(c0 + W + 1, 4'd0, K2);
    go_cycle(c0 + W + 1 + T);
    check("R6 no early fault past window", rst_pulses, 0);
    go_cycle(c0 + W + T + 6);
    check("R6 accepted past window", rst_first, c0 + W + 1 + 2 + T);
    stop_run();
    win_en = 1'b0;
  endtask

  task automatic t_irq_first();
    int c0;
    irq_first = 1'b1;
    start_run(c0);
    wr_at(c0 + 5, 4'd0, 16'h0001);
    go_cycle(c0 + 6 + D + 4);
    check("R4 irq rise cycle", irq_first_cyc, c0 + 6);
    check("R4 irq length", irq_hi, D);
    check("R4 reset after delay", rst_first, c0 + 6 + D);
    stop_run();
    irq_first = 1'b0;
  endtask

  task automatic t_disable();
    int c0;
    int c1;
    start_run(c0);
    go_cycle(c0 + 30);
    enable = 1'b0;
    wr_at(c0 + 32, 4'd0, 16'h1234);
    go_cycle(c0 + 35);
    enable = 1'b1;
    c1 = cyc;
    go_cycle(c1 + T + 4);
    check("R8 count restarts from zero", rst_first, c1 + T + 1);
    check("R8 write while off ignored", rst_pulses, 1);
    stop_run();
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    t_reset_state();
    t_timeout();
    t_refresh();
    t_gap();
    t_bad_word();
    t_unlock();
    t_window();
    t_irq_first();
    t_disable();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule